// File: doc/BRIEF.md
# Read Strobe Clock Run-Policy Controller

This block decides when a memory device drives its outgoing read strobe clock. It runs on the fast write clock and divides that clock by four to make an internal reference clock, which the device uses for latency timing. It is told which policy to follow by a two-bit mode field, and it receives three single-cycle command strobes: clock start, clock stop, and any command that returns read data. A sleep flag is also an input. From these it produces an enable and a gated copy of the reference clock that serves as the read strobe clock.

Decisions are taken once per reference period, on the write-clock edge that ends the reference high phase. The mode field and the sleep flag are sampled there. Command strobes that arrive during the period are held until that edge. Because the enable can change only as the reference clock goes low, the gated output carries whole pulses or none at all.

The controller is a five-state machine:
- `S_DISABLED`: disabled mode, stopped.
- `S_FREE`: always-running mode, toggling.
- `S_SLEEP_HALT`: always-running mode, halted by sleep.
- `S_PARKED`: a command-driven mode, waiting for its trigger.
- `S_ACTIVE`: a command-driven mode, toggling.

At each decision edge the next state follows from the sampled mode:
- Mode 00 goes to `S_FREE`, or to `S_SLEEP_HALT` when sleep is set.
- Mode 01 goes to `S_DISABLED`.
- Modes 10 and 11 go to `S_PARKED` on a stop. They go to `S_ACTIVE` on their trigger, or when the block is already in `S_ACTIVE`. Otherwise they go to `S_PARKED`.

Top module: `rdclk_mode_ctrl`

## Requirements
- R1: The reference output is the write clock divided by four. After reset it is low for two write-clock cycles, then high for two, and this repeats.
- R2: While reset is asserted, and after its release, the enable and the read clock are low. The block starts in the disabled state.
- R3: Mode 2'b00 (always running) without sleep sets the enable, and the read clock equals the reference output.
- R4: In mode 2'b00, sleep sampled at a decision edge stops the read clock. Once sleep is low, toggling resumes at the next decision edge, which is within one reference period.
- R5: Mode 2'b01 (disabled) keeps the enable and the read clock low whatever commands arrive.
- R6: In mode 2'b10 (command start), a start strobe turns the clock on and a stop strobe turns it off. This can be repeated, and read strobes have no effect.
- R7: In mode 2'b11 (read start), any read-data strobe turns the clock on, only a stop strobe turns it off, and start strobes have no effect.
- R8: When a stop strobe and a trigger strobe fall within the same reference period, the clock ends that period stopped.
- R9: The enable changes only on the write-clock edge where the reference output falls, and the read clock is high only while the reference output is high. A mode change therefore takes effect at the next decision edge and never produces a partial pulse.
- R10: In mode 2'b00, start and stop strobes do not interrupt toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Run policy: 00 always, 01 disabled, 10 command start, 11 read start |
| start_cmd_i | input | 1 | Clock start command strobe |
| stop_cmd_i | input | 1 | Clock stop command strobe |
| read_cmd_i | input | 1 | Strobe for any command returning read data |
| sleep_i | input | 1 | Device is in a sleep state |
| ref_clk_o | output | 1 | Divide-by-four reference clock |
| rclk_en_o | output | 1 | Read clock enable |
| rclk_o | output | 1 | Gated read strobe clock |

## Verification
The bench builds the block with its default divide exponent of two, which gives a four-cycle reference period. At that setting every position of a strobe within the period can be reached in a few cycles, including the cycle that is itself the decision edge. The scenarios place commands, mode changes and sleep transitions at varied phases. A behavioural model then checks that the enable moves only at reference falls and that stop outranks a trigger in the same period.

// File: rtl/rdclk_pkg.sv
package rdclk_pkg;

    typedef enum logic [1:0] {
        MODE_ALWAYS = 2'b00,
        MODE_OFF    = 2'b01,
        MODE_CMD    = 2'b10,
        MODE_READ   = 2'b11
    } rck_mode_e;

    typedef enum logic [2:0] {
        S_DISABLED   = 3'd0,
        S_FREE       = 3'd1,
        S_SLEEP_HALT = 3'd2,
        S_PARKED     = 3'd3,
        S_ACTIVE     = 3'd4
    } rck_state_e;

    localparam int unsigned CMD_START = 0;
    localparam int unsigned CMD_STOP  = 1;
    localparam int unsigned CMD_READ  = 2;
    localparam int unsigned NUM_CMDS  = 3;

endpackage

// File: rtl/rck_refdiv.sv
module rck_refdiv #(
    parameter int unsigned DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_o,
    output logic tick_o
);
    localparam int unsigned PW = (DIV_LOG2 < 1) ? 1 : DIV_LOG2;

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // High half of the count is the high phase of the reference.
    assign ref_o  = phase_q[PW-1];
    // Last write-clock cycle of the period: decision edge follows.
    assign tick_o = &phase_q;
endmodule

// File: rtl/rck_cmd_latch.sv
module rck_cmd_latch #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [N-1:0] strobe_i,
    output logic [N-1:0] seen_o
);
    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (tick_i) begin
                pend_q[g] <= 1'b0;
            end else if (strobe_i[g]) begin
                pend_q[g] <= 1'b1;
            end
        end
        // A strobe in the decision cycle itself still counts.
        assign seen_o[g] = pend_q[g] | strobe_i[g];
    end
endmodule

// File: rtl/rck_policy_fsm.sv
module rck_policy_fsm
    import rdclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  rck_mode_e mode_i,
    input  logic      sleep_i,
    input  logic      start_seen_i,
    input  logic      stop_seen_i,
    input  logic      read_seen_i,
    output logic      en_o
);
    rck_state_e state_q, state_d;
    logic       trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_DISABLED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        trig    = 1'b0;
        if (tick_i) begin
            unique case (mode_i)
                MODE_ALWAYS: state_d = sleep_i ? S_SLEEP_HALT : S_FREE;
                MODE_OFF:    state_d = S_DISABLED;
                MODE_CMD, MODE_READ: begin
                    trig = (mode_i == MODE_CMD) ? start_seen_i : read_seen_i;
                    if (stop_seen_i) begin
                        state_d = S_PARKED;
                    end else if (trig || state_q == S_ACTIVE) begin
                        state_d = S_ACTIVE;
                    end else begin
                        state_d = S_PARKED;
                    end
                end
                default: state_d = S_DISABLED;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_FREE, S_ACTIVE:                       en_o = 1'b1;
            S_DISABLED, S_SLEEP_HALT, S_PARKED:     en_o = 1'b0;
            default:                                en_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdclk_mode_ctrl.sv
module rdclk_mode_ctrl
    import rdclk_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       start_cmd_i,
    input  logic       stop_cmd_i,
    input  logic       read_cmd_i,
    input  logic       sleep_i,
    output logic       ref_clk_o,
    output logic       rclk_en_o,
    output logic       rclk_o
);
    logic                tick;
    logic [NUM_CMDS-1:0] strobes;
    logic [NUM_CMDS-1:0] seen;

    rck_refdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_o  (ref_clk_o),
        .tick_o (tick)
    );

    assign strobes[CMD_START] = start_cmd_i;
    assign strobes[CMD_STOP]  = stop_cmd_i;
    assign strobes[CMD_READ]  = read_cmd_i;

    rck_cmd_latch #(.N(NUM_CMDS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .strobe_i (strobes),
        .seen_o   (seen)
    );

    rck_policy_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .mode_i       (rck_mode_e'(mode_i)),
        .sleep_i      (sleep_i),
        .start_seen_i (seen[CMD_START]),
        .stop_seen_i  (seen[CMD_STOP]),
        .read_seen_i  (seen[CMD_READ]),
        .en_o         (rclk_en_o)
    );

    assign rclk_o = rclk_en_o & ref_clk_o;
endmodule

// File: rtl/rdclk_mode_ctrl_chk.sv
module rdclk_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       sleep_i,
    input logic       ref_clk_o,
    input logic       rclk_en_o,
    input logic       rclk_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R2: assert (!rclk_en_o && !rclk_o)
                else $error("enable or clock high in reset");
        end
    end

    assert_ref_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_clk_o) |=> (ref_clk_o ##1 !ref_clk_o));

    assert_en_at_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rclk_en_o) |-> $fell(ref_clk_o));

    assert_no_partial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rclk_o |-> ref_clk_o);

    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_clk_o) && $past(mode_i) == 2'b01) |-> !rclk_en_o);

    assert_sleep_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_clk_o) && $past(mode_i) == 2'b00 && $past(sleep_i)) |-> !rclk_en_o);

    assert_free_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_clk_o) && $past(mode_i) == 2'b00 && !$past(sleep_i)) |-> rclk_en_o);
endmodule

bind rdclk_mode_ctrl rdclk_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .sleep_i   (sleep_i),
    .ref_clk_o (ref_clk_o),
    .rclk_en_o (rclk_en_o),
    .rclk_o    (rclk_o)
);

// File: tb/rdclk_mode_ctrl_bench.sv
module rdclk_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b01;
    logic       start_cmd_i = 1'b0;
    logic       stop_cmd_i = 1'b0;
    logic       read_cmd_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       ref_clk_o, rclk_en_o, rclk_o;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string req = "R2";

    // Behavioural reference model
    int m_phase = 0;
    bit m_en = 0;
    bit m_run = 0;
    bit p_start = 0, p_stop = 0, p_read = 0;

    always #2 clk = ~clk;

    rdclk_mode_ctrl u_rdclk_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .start_cmd_i(start_cmd_i), .stop_cmd_i(stop_cmd_i),
        .read_cmd_i(read_cmd_i), .sleep_i(sleep_i),
        .ref_clk_o(ref_clk_o), .rclk_en_o(rclk_en_o), .rclk_o(rclk_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 0; m_en <= 0; m_run <= 0;
            p_start <= 0; p_stop <= 0; p_read <= 0;
        end else begin
            bit st, sp, rd, trig, nrun;
            st = p_start | start_cmd_i;
            sp = p_stop | stop_cmd_i;
            rd = p_read | read_cmd_i;
            if (m_phase == 3) begin
                p_start <= 0; p_stop <= 0; p_read <= 0;
                case (mode_i)
                    2'b00: begin m_en <= !sleep_i; m_run <= 0; end
                    2'b01: begin m_en <= 0; m_run <= 0; end
                    default: begin
                        trig = (mode_i == 2'b10) ? st : rd;
                        nrun = sp ? 1'b0 : (trig ? 1'b1 : m_run);
                        m_run <= nrun;
                        m_en <= nrun;
                    end
                endcase
            end else begin
                p_start <= st; p_stop <= sp; p_read <= rd;
            end
            m_phase <= (m_phase + 1) % 4;
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        bit e_ref, e_clk;
        e_ref = (m_phase >= 2);
        e_clk = m_en && e_ref;
        vectors++;
        if (ref_clk_o !== e_ref) begin
            fails++;
            $display("FAIL R1 (%s) cycle %0d ref actual=%b expected=%b", req, cycles, ref_clk_o, e_ref);
        end
        if (rclk_en_o !== m_en) begin
            fails++;
            $display("FAIL %s cycle %0d enable actual=%b expected=%b", req, cycles, rclk_en_o, m_en);
        end
        if (rclk_o !== e_clk) begin
            fails++;
            $display("FAIL %s cycle %0d rclk actual=%b expected=%b", req, cycles, rclk_o, e_clk);
        end
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: start_cmd_i = 1'b1;
            1: stop_cmd_i  = 1'b1;
            default: read_cmd_i = 1'b1;
        endcase
        @(negedge clk);
        start_cmd_i = 1'b0; stop_cmd_i = 1'b0; read_cmd_i = 1'b0;
    endtask

    initial begin
        req = "R2"; wait_n(4);
        @(negedge clk) rst_n = 1'b1;
        wait_n(12);                       // R2 stopped after reset
        req = "R5";                       // R5 disabled ignores commands
        pulse(0); wait_n(6); pulse(2); wait_n(9);
        req = "R3"; mode_i = 2'b00; wait_n(30);   // R3 free run
        req = "R10"; pulse(1); wait_n(5); pulse(0); wait_n(11); // R10
        req = "R4"; sleep_i = 1'b1; wait_n(21);   // R4 sleep halts
        sleep_i = 1'b0; wait_n(13);
        @(negedge clk) sleep_i = 1'b1; @(negedge clk) sleep_i = 1'b0; wait_n(9);
        req = "R9"; mode_i = 2'b01; wait_n(3); mode_i = 2'b00; wait_n(7);
        req = "R6"; mode_i = 2'b10; wait_n(10);   // R6 parked
        pulse(2); wait_n(13);
        pulse(0); wait_n(22);
        pulse(1); wait_n(15);
        pulse(0); wait_n(10); pulse(1); wait_n(9); pulse(0); wait_n(14);
        req = "R7"; mode_i = 2'b11; wait_n(10);   // R7 stays on across switch
        pulse(1); wait_n(11);
        pulse(0); wait_n(13);
        pulse(2); wait_n(21);
        pulse(2); wait_n(7);
        pulse(1); wait_n(10);
        req = "R8";                               // R8 stop outranks trigger
        @(negedge clk) begin read_cmd_i = 1'b1; stop_cmd_i = 1'b1; end
        @(negedge clk) begin read_cmd_i = 1'b0; stop_cmd_i = 1'b0; end
        wait_n(11);
        mode_i = 2'b10;
        for (int k = 0; k < 4; k++) begin
            wait_n(k);
            pulse(0); pulse(1); wait_n(9);
            pulse(1); pulse(0); wait_n(9);
            pulse(1); wait_n(8);
        end
        req = "R9"; mode_i = 2'b01; wait_n(2); mode_i = 2'b11; wait_n(1);
        pulse(2); wait_n(5); mode_i = 2'b00; wait_n(9);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule